// File: doc/BRIEF.md
# Dual-Socket Card Status Change Interrupt Unit

This block watches the status pins of two removable-card sockets and turns their activity into a single level interrupt for a host processor. Every pin is first brought into the local clock domain through a synchronizer chain. The synchronized values can be read as a live pin status word. Edges on those values set sticky bits in a change word. An enable word selects which change bits may raise the interrupt.

The two sockets share every 32-bit word. Slot A occupies the upper 16 bits and slot B the lower 16 bits, and both halves use the same layout. Software reads and writes the three words through a small register port. It clears change bits by writing ones. A per-slot card-present output is asserted when both card detect pins of that slot are low.

Top module: `sockStatusIrq`

## Requirements
- R1: After reset the change word and the enable word read zero, and irq is low.
- R2: The pin status word (regSel 0) holds each slot's synchronized pins in bits 15:8 of its half: VS1, VS2, write protect, CD2, CD1, BVD2, BVD1, ready, from bit 15 down. Slot A's half is 31:16 and slot B's half is 15:0. Bits 7:0 of each half read zero.
- R3: An edge in either direction on a synchronized pin sets the change bit (regSel 1) in the same position as its pin status bit. The bit stays set after the pin returns to its old value.
- R4: Writing the change word clears every latched bit written with one and leaves the bits written with zero unchanged.
- R5: The enable word (regSel 2) is written and read directly. irq is high exactly when some change bit and its enable bit are both one.
- R6: irq is the registered OR of (change AND enable), so it follows the change and enable words one clock later.
- R7: cardPresent[0] (slot A) and cardPresent[1] (slot B) are high only while that slot's synchronized CD1 and CD2 are both low.
- R8: A change on CD1 or CD2 sets its change bit only if, after the change, CD1 and CD2 read the same value.
- R9: Change bit 7 of a half is the live inverse of ready and bit 6 is the live ready level. Neither bit is latched, and a write of one does not clear them.
- R10: Change bit 5 of a half latches a rising edge of ready and bit 4 latches a falling edge. Both are cleared by writing one.
- R11: When a pin edge and a write-one-to-clear hit the same change bit on the same clock edge, the bit ends set.
- R12: Only bits 15:4 of each half of the enable word are writable. The other bits always read zero.
- R13: Until the synchronizers have filled after reset, every change bit reads zero. Pin values already present during reset do not produce change events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sockPins | input | 16 | Raw socket pins. Slot A is in 15:8 and slot B in 7:0, each ordered VS1, VS2, WP, CD2, CD1, BVD2, BVD1, ready from the MSB |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 pin status, 1 change, 2 enable, 3 reads zero |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register |
| irq | output | 1 | Combined level interrupt |
| cardPresent | output | 2 | Bit 0 slot A present, bit 1 slot B present |

## Verification
The bench builds the unit with the default two-stage synchronizer. With that depth, a pin edge reaches the change word exactly three clocks after it is driven. This lets the bench place a clearing write on the very edge where a new event lands and check that the set wins. The shallow chain also keeps the post-reset blanking window short, so the bench can show that pins held high through reset raise no change bits. Card insertion is driven with the two detect pins falling at different times, which exercises the agreement rule for detect events.

// File: rtl/sockStatusPkg.sv
package sockStatusPkg;
  localparam int NUM_SLOTS = 2;
  localparam int HALF_W    = 16;
  localparam int PIN_W     = 8;
  localparam int REG_W     = NUM_SLOTS * HALF_W;
  localparam int PIN_BASE  = HALF_W - PIN_W;

  localparam int CD2_PIN   = 4;
  localparam int CD1_PIN   = 3;
  localparam int RDY_PIN   = 0;

  localparam int LVL_LO_BIT = 7;
  localparam int LVL_HI_BIT = 6;
  localparam int RISE_BIT   = 5;
  localparam int FALL_BIT   = 4;

  localparam logic [HALF_W-1:0] LATCH_MASK  = 16'hFF30;
  localparam logic [HALF_W-1:0] ENABLE_MASK = 16'hFFF0;

  typedef enum logic [1:0] {
    SEL_PINS   = 2'd0,
    SEL_CHANGE = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrChange;
    logic wrEnable;
    logic arm;
  } ctrlStrobes_t;
endpackage

// File: rtl/sockStatusControl.sv
module sockStatusControl
  import sockStatusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   regSel,
  output ctrlStrobes_t strobes
);
  localparam int WARM_LIMIT = SYNC_STAGES + 1;
  localparam int WARM_W     = $clog2(WARM_LIMIT + 1);

  logic [WARM_W-1:0] warmCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (warmCnt != WARM_W'(WARM_LIMIT)) begin
      warmCnt <= warmCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.wrChange = wrEn && (regSel == SEL_CHANGE);
    strobes.wrEnable = wrEn && (regSel == SEL_ENABLE);
    strobes.arm      = (warmCnt == WARM_W'(WARM_LIMIT));
  end
endmodule

// File: rtl/sockStatusDatapath.sv
module sockStatusDatapath
  import sockStatusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SLOTS*PIN_W-1:0] sockPins,
  input  ctrlStrobes_t               strobes,
  input  logic [1:0]                 regSel,
  input  logic [REG_W-1:0]           wrData,
  output logic [REG_W-1:0]           rdData,
  output logic                       irq,
  output logic [NUM_SLOTS-1:0]       cardPresent,
  output logic [REG_W-1:0]           statView,
  output logic [REG_W-1:0]           chgView,
  output logic [REG_W-1:0]           enView
);
  logic [NUM_SLOTS-1:0] slotPending;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    localparam int HI  = REG_W - 1 - s * HALF_W;
    localparam int PHI = (NUM_SLOTS - s) * PIN_W - 1;

    logic [PIN_W-1:0]  syncStage [SYNC_STAGES];
    logic [PIN_W-1:0]  pinSync;
    logic [PIN_W-1:0]  pinPrev;
    logic [PIN_W-1:0]  edges;
    logic [PIN_W-1:0]  detMask;
    logic [HALF_W-1:0] setVec;
    logic [HALF_W-1:0] clrVec;
    logic [HALF_W-1:0] levelVec;
    logic [HALF_W-1:0] latched;
    logic [HALF_W-1:0] enable;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int k = 0; k < SYNC_STAGES; k++) syncStage[k] <= '0;
        pinPrev <= '0;
      end else begin
        syncStage[0] <= sockPins[PHI -: PIN_W];
        for (int k = 1; k < SYNC_STAGES; k++) syncStage[k] <= syncStage[k-1];
        pinPrev <= pinSync;
      end
    end

    assign pinSync = syncStage[SYNC_STAGES-1];
    assign edges   = pinSync ^ pinPrev;

    always_comb begin
      detMask = '1;
      if (pinSync[CD1_PIN] != pinSync[CD2_PIN]) begin
        detMask[CD1_PIN] = 1'b0;
        detMask[CD2_PIN] = 1'b0;
      end
      setVec = '0;
      setVec[HALF_W-1 -: PIN_W] = edges & detMask;
      setVec[RISE_BIT] = pinSync[RDY_PIN] & ~pinPrev[RDY_PIN];
      setVec[FALL_BIT] = ~pinSync[RDY_PIN] & pinPrev[RDY_PIN];
      if (!strobes.arm) setVec = '0;

      clrVec = strobes.wrChange ? (wrData[HI -: HALF_W] & LATCH_MASK) : '0;

      levelVec = '0;
      levelVec[LVL_LO_BIT] = strobes.arm & ~pinSync[RDY_PIN];
      levelVec[LVL_HI_BIT] = strobes.arm & pinSync[RDY_PIN];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        latched <= '0;
        enable  <= '0;
      end else begin
        latched <= (latched & ~clrVec) | setVec;
        if (strobes.wrEnable) enable <= wrData[HI -: HALF_W] & ENABLE_MASK;
      end
    end

    assign statView[HI -: HALF_W] = {pinSync, {PIN_BASE{1'b0}}};
    assign chgView[HI -: HALF_W]  = latched | levelVec;
    assign enView[HI -: HALF_W]   = enable;
    assign slotPending[s]         = |((latched | levelVec) & enable);
    assign cardPresent[s]         = ~pinSync[CD1_PIN] & ~pinSync[CD2_PIN];
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |slotPending;
  end

  always_comb begin
    case (regSel)
      SEL_PINS:   rdData = statView;
      SEL_CHANGE: rdData = chgView;
      SEL_ENABLE: rdData = enView;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/sockStatusIrq.sv
module sockStatusIrq
  import sockStatusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] sockPins,
  input  logic        wrEn,
  input  logic [1:0]  regSel,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq,
  output logic [1:0]  cardPresent
);
  ctrlStrobes_t     strobes;
  logic [REG_W-1:0] statView;
  logic [REG_W-1:0] chgView;
  logic [REG_W-1:0] enView;

  sockStatusControl #(.SYNC_STAGES(SYNC_STAGES)) u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .strobes(strobes)
  );

  sockStatusDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .sockPins(sockPins), .strobes(strobes),
    .regSel(regSel), .wrData(wrData), .rdData(rdData), .irq(irq),
    .cardPresent(cardPresent), .statView(statView), .chgView(chgView),
    .enView(enView)
  );
endmodule

// File: rtl/sockStatusIrqChecker.sv
module sockStatusIrqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  regSel,
  input logic        arm,
  input logic [31:0] statView,
  input logic [31:0] chgView,
  input logic [31:0] enView,
  input logic        irq,
  input logic [1:0]  cardPresent
);
  logic [31:0] latchedAll;
  assign latchedAll = chgView & 32'hFF30_FF30;

  assert_sticky_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && regSel == 2'd1) |-> ((latchedAll & $past(latchedAll)) == $past(latchedAll)));

  assert_enable_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn && regSel == 2'd2) |-> $stable(enView));

  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(|(chgView & enView)) |-> irq);

  assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|(chgView & enView)) |-> !irq);

  assert_present_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    cardPresent[0] == (statView[28:27] == 2'b00));

  assert_present_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    cardPresent[1] == (statView[12:11] == 2'b00));

  assert_quiet_warmup_R13: assert property (@(posedge clk) disable iff (!rstN)
    !arm |-> (chgView == 32'h0));
endmodule

bind sockStatusIrq sockStatusIrqChecker u_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel), .arm(strobes.arm),
  .statView(statView), .chgView(chgView), .enView(enView), .irq(irq),
  .cardPresent(cardPresent)
);

// File: tb/sockStatusIrq_bench.sv
module sockStatusIrq_bench;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pins = 16'hFFFF;
  logic        wrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic        irq;
  logic [1:0]  cardPresent;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  sockStatusIrq #(.SYNC_STAGES(SYNC)) u_sockStatusIrq (
    .clk(clk), .rstN(rstN), .sockPins(pins), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .irq(irq), .cardPresent(cardPresent)
  );

  // monitor: compares the item pushed at the preceding negedge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = rdData;
          1:       act = {31'h0, irq};
          default: act = {30'h0, cardPresent};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expectVal(input int kind, input logic [1:0] sel,
                           input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    regSel = sel;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regSel = sel; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (SYNC + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 / R13: quiet right after reset
    expectVal(0, 2'd1, 32'h0, "R1 change after reset");
    expectVal(0, 2'd2, 32'h0, "R1 enable after reset");
    expectVal(1, 2'd0, 32'h0, "R1 irq after reset");
    settle();
    expectVal(0, 2'd1, 32'h0040_0040, "R13 no events from reset pins");
    expectVal(0, 2'd0, 32'hFF00_FF00, "R2 pin status all high");

    // new pin pattern: slot A 0xA5, slot B 0x3C
    @(negedge clk); pins = 16'hA53C;
    settle();
    expectVal(0, 2'd0, 32'hA500_3C00, "R2 pin status layout");
    expectVal(0, 2'd1, 32'h5A40_C390, "R3 R10 edges latched");
    expectVal(2, 2'd0, 32'h1, "R7 slot A present only");

    // R4 write one to clear
    wrReg(2'd1, 32'h5A00_0000);
    expectVal(0, 2'd1, 32'h0040_C390, "R4 clear slot A edges");
    wrReg(2'd1, 32'h0);
    expectVal(0, 2'd1, 32'h0040_C390, "R4 zero write no effect");
    wrReg(2'd1, 32'h0000_00C0);
    expectVal(0, 2'd1, 32'h0040_C390, "R9 level bits not clearable");
    wrReg(2'd1, 32'hFFFF_FFFF);
    expectVal(0, 2'd1, 32'h0040_0080, "R4 R10 clear all latched");

    // R12 / R5 enable and irq
    wrReg(2'd2, 32'hFFFF_FFFF);
    expectVal(0, 2'd2, 32'hFFF0_FFF0, "R12 enable writable bits");
    expectVal(1, 2'd0, 32'h1, "R5 irq with enabled change");
    wrReg(2'd2, 32'h0);
    expectVal(1, 2'd0, 32'h0, "R5 irq off when disabled");
    wrReg(2'd2, 32'h0000_0080);
    expectVal(1, 2'd0, 32'h1, "R9 ready-low level drives irq");
    wrReg(2'd2, 32'h0);

    // R8 detect agreement: CD1 rises alone, then CD2
    @(negedge clk); pins = 16'hAD3C;
    settle();
    expectVal(0, 2'd1, 32'h0040_0080, "R8 lone CD1 change ignored");
    expectVal(2, 2'd0, 32'h0, "R7 no card with one detect high");
    @(negedge clk); pins = 16'hBD3C;
    settle();
    expectVal(0, 2'd1, 32'h1040_0080, "R8 CD2 change when pins agree");

    // R10 ready rising on slot B
    @(negedge clk); pins = 16'hBD3D;
    settle();
    expectVal(0, 2'd1, 32'h1040_0160, "R10 ready rise and levels");

    // R11 set wins over clear
    wrReg(2'd1, 32'hFFFF_FFFF);
    expectVal(0, 2'd1, 32'h0040_0040, "R4 cleared before collision");
    @(negedge clk); pins = 16'h9D3D;
    settle();
    expectVal(0, 2'd1, 32'h2040_0040, "R3 write protect edge");
    @(negedge clk); pins = 16'hBD3D;
    repeat (SYNC) @(negedge clk);
    regSel = 2'd1; wrData = 32'h2000_0000; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    settle();
    expectVal(0, 2'd1, 32'h2040_0040, "R11 set wins over clear");
    wrReg(2'd1, 32'h2000_0000);
    expectVal(0, 2'd1, 32'h0040_0040, "R4 clear after collision");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule